// File: doc/BRIEF.md
# SECDED Memory Wrapper with Write-Back Repair and Hard-Error Cache

This block sits between a processor-side read/write port and a single-port SRAM. Every word is stored with single-error-correct, double-error-detect check bits. A read decodes the stored word.

On a correctable single-bit error the block does four things in turn. It writes the corrected word back into the array. It records the failing address and the corrected data in a one-entry hard-error cache. It counts the event against a programmable threshold. Then it retries the access. Later reads of the cached address are answered from the cache without reading the array. A new single-bit error at another address replaces the cache entry. A double-bit error is reported as uncorrectable and changes nothing.

A requester raises `req` with the command and holds it until `rdy` pulses. For test and diagnosis, a write can XOR an injection mask into the stored codeword.

Top module: `ecc_hec_mem`

## Requirements
- R1: After reset, `rdy` and `thr_irq` are 0, `sbe_cnt` is 0, the threshold is 4 and the cache is empty, so the first read of any address goes to the array.
- R2: A write completes with a one-cycle `rdy` pulse 1 cycle after it is accepted. A read of an error-free word returns the written data 3 cycles after acceptance, with `rd_hit`, `rd_sbe` and `rd_ue` at 0.
- R3: The stored codeword is {overall parity [38], six Hamming check bits [37:32], data [31:0]}. A write stores that codeword XOR `inj_flip`. A read that finds one flipped data bit returns the corrected data with `rd_sbe`=1, 6 cycles after acceptance.
- R4: After a correction, the array holds the repaired word. Once the cache has moved to another address, a later read of the repaired address is clean: latency 3, `rd_sbe`=0.
- R5: After a correction, a read of that address hits the cache. It returns the corrected data with `rd_hit`=1 and no error flags, 1 cycle after acceptance.
- R6: The cache holds one entry. A single-bit error at a new address replaces it, so the new address hits and the old one misses.
- R7: A write to the cached address also updates the cached data, so a following hit returns the new value.
- R8: A single flipped check bit (bits 32 to 38, overall parity included) is treated as a correctable error. The data is returned intact, the event is counted, and the word is repaired and cached.
- R9: Two flipped bits give `rd_ue`=1 with the stored data field returned unchanged, 3 cycles after acceptance. The count, the cache and the array are left as they were, so a repeat read flags `rd_ue` again.
- R10: `sbe_cnt` rises by one for each corrected event and saturates at its maximum.
- R11: When the threshold is nonzero and `sbe_cnt` reaches it, `thr_irq` is set. It stays set until a configuration write.
- R12: A configuration write (`cfg_we`) loads the threshold from `cfg_thr` and clears `sbe_cnt` and `thr_irq`. A threshold of 0 never raises `thr_irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | 1 | Access request, held until `rdy` |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | ADDR_W | Word address |
| wdata | input | DATA_W | Write data |
| inj_flip | input | DATA_W+7 | Bits XORed into the stored codeword on a write |
| rdy | output | 1 | One-cycle pulse ending an access |
| rdata | output | DATA_W | Read data, valid with `rdy` |
| rd_hit | output | 1 | Read was served by the hard-error cache |
| rd_sbe | output | 1 | Read found and corrected a single-bit error |
| rd_ue | output | 1 | Read found an uncorrectable error |
| cfg_we | input | 1 | Threshold register write |
| cfg_thr | input | THR_W | New threshold value |
| sbe_cnt | output | THR_W | Saturating single-bit event count |
| thr_irq | output | 1 | Sticky threshold interrupt |

## Verification
Each access type has a fixed latency, counted from the clock edge that accepts `req` to the cycle in which `rdy` is seen:
- a write or a cache hit takes 1 cycle;
- a clean read or an uncorrectable read takes 3 cycles;
- a corrected read takes 6 cycles, made up of read, check, write-back, retry, check and done.

The driver computes the expected latency and result from its own model of array contents, cache and counter, then records the cycle of issue. The monitor samples on the falling edge after `rdy` rises and compares the elapsed cycle count as well as the data and flags. Counter and interrupt checks are made only after the access that moves them has returned.

// File: rtl/ecc_hec_mem.sv
module ecc_hec_mem #(
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 32,
  parameter int THR_W   = 4,
  parameter int THR_RST = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req,
  input  logic                  we,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [DATA_W-1:0]     wdata,
  input  logic [DATA_W+6:0]     inj_flip,
  output logic                  rdy,
  output logic [DATA_W-1:0]     rdata,
  output logic                  rd_hit,
  output logic                  rd_sbe,
  output logic                  rd_ue,
  input  logic                  cfg_we,
  input  logic [THR_W-1:0]      cfg_thr,
  output logic [THR_W-1:0]      sbe_cnt,
  output logic                  thr_irq
);

  function automatic int calc_p(int dw);
    int p;
    p = 1;
    while ((1 << p) < dw + p + 1) p++;
    return p;
  endfunction

  localparam int P     = calc_p(DATA_W);
  localparam int NPOS  = DATA_W + P;
  localparam int CW    = NPOS + 1;
  localparam int DEPTH = 1 << ADDR_W;

  function automatic int dpos(int idx);
    int n, r;
    n = 0;
    r = 0;
    for (int p = 3; p <= NPOS; p++) begin
      if ((p & (p - 1)) != 0) begin
        if (n == idx) r = p;
        n++;
      end
    end
    return r;
  endfunction

  function automatic logic [P-1:0] hgen(logic [DATA_W-1:0] d);
    logic [P-1:0] h;
    h = '0;
    for (int j = 0; j < P; j++)
      for (int i = 0; i < DATA_W; i++)
        if (((dpos(i) >> j) & 1) == 1) h[j] = h[j] ^ d[i];
    return h;
  endfunction

  function automatic logic [CW-1:0] enc(logic [DATA_W-1:0] d);
    logic [P-1:0] h;
    h = hgen(d);
    return {^{h, d}, h, d};
  endfunction

  typedef enum logic [2:0] {S_IDLE, S_READ, S_CHECK, S_WB, S_RETRY, S_DONE} st_t;

  st_t                 st;
  logic [CW-1:0]       mem [DEPTH];
  logic [CW-1:0]       rd_q;
  logic [ADDR_W-1:0]   a_q;
  logic                retried;
  logic                cv;
  logic [ADDR_W-1:0]   ca;
  logic [DATA_W-1:0]   cd;
  logic [THR_W-1:0]    thr_q;

  logic [DATA_W-1:0]   d_s, corr;
  logic [P-1:0]        syn;
  logic                ov, single_w, ue_w;
  logic                hit_w, mem_we, mem_re;
  logic [ADDR_W-1:0]   mem_wa;
  logic [CW-1:0]       mem_wd;
  logic [THR_W-1:0]    cnt_nx;

  assign d_s      = rd_q[DATA_W-1:0];
  assign syn      = hgen(d_s) ^ rd_q[DATA_W +: P];
  assign ov       = ^rd_q;
  assign single_w = ov && (int'(syn) <= NPOS);
  assign ue_w     = ov ? (int'(syn) > NPOS) : (syn != '0);

  always_comb begin
    for (int i = 0; i < DATA_W; i++)
      corr[i] = d_s[i] ^ (int'(syn) == dpos(i));
  end

  assign hit_w  = cv && (ca == addr);
  assign mem_we = (st == S_IDLE && req && we) || (st == S_WB);
  assign mem_wa = (st == S_IDLE) ? addr : a_q;
  assign mem_wd = (st == S_IDLE) ? (enc(wdata) ^ inj_flip) : enc(corr);
  assign mem_re = (st == S_READ) || (st == S_RETRY);
  assign cnt_nx = (&sbe_cnt) ? sbe_cnt : sbe_cnt + 1'b1;
  assign rdy    = (st == S_DONE);

  always_ff @(posedge clk) begin
    if (mem_we) mem[mem_wa] <= mem_wd;
    if (mem_re) rd_q <= mem[a_q];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      a_q     <= '0;
      retried <= 1'b0;
      rdata   <= '0;
      rd_hit  <= 1'b0;
      rd_sbe  <= 1'b0;
      rd_ue   <= 1'b0;
      cv      <= 1'b0;
      ca      <= '0;
      cd      <= '0;
    end else begin
      case (st)
        S_IDLE: if (req) begin
          a_q     <= addr;
          rd_hit  <= 1'b0;
          rd_sbe  <= 1'b0;
          rd_ue   <= 1'b0;
          retried <= 1'b0;
          if (we) begin
            if (hit_w) cd <= wdata;
            st <= S_DONE;
          end else if (hit_w) begin
            rdata  <= cd;
            rd_hit <= 1'b1;
            st     <= S_DONE;
          end else begin
            st <= S_READ;
          end
        end
        S_READ:  st <= S_CHECK;
        S_RETRY: st <= S_CHECK;
        S_CHECK: begin
          if (ue_w) begin
            rdata <= d_s;
            rd_ue <= 1'b1;
            st    <= S_DONE;
          end else if (single_w && !retried) begin
            rd_sbe <= 1'b1;
            st     <= S_WB;
          end else begin
            rdata <= corr;
            st    <= S_DONE;
          end
        end
        S_WB: begin
          cv      <= 1'b1;
          ca      <= a_q;
          cd      <= corr;
          retried <= 1'b1;
          st      <= S_RETRY;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      thr_q   <= THR_W'(THR_RST);
      sbe_cnt <= '0;
      thr_irq <= 1'b0;
    end else if (cfg_we) begin
      thr_q   <= cfg_thr;
      sbe_cnt <= '0;
      thr_irq <= 1'b0;
    end else if (st == S_WB) begin
      sbe_cnt <= cnt_nx;
      if (thr_q != '0 && cnt_nx >= thr_q) thr_irq <= 1'b1;
    end
  end

endmodule

// File: rtl/ecc_hec_mem_chk.sv
module ecc_hec_mem_chk #(
  parameter int THR_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rdy,
  input logic             rd_hit,
  input logic             rd_sbe,
  input logic             rd_ue,
  input logic             cfg_we,
  input logic [THR_W-1:0] sbe_cnt,
  input logic             thr_irq
);

  assert_rdy_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rdy |=> !rdy);

  assert_hit_clean_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rdy && rd_hit) |-> (!rd_sbe && !rd_ue));

  assert_ue_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rdy && rd_ue) |-> !rd_sbe);

  assert_cnt_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> (sbe_cnt == $past(sbe_cnt)) || (sbe_cnt == THR_W'($past(sbe_cnt) + 1'b1)));

  assert_irq_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (thr_irq && !cfg_we) |=> thr_irq);

  assert_irq_cause_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(thr_irq) |-> (sbe_cnt != $past(sbe_cnt)));

  assert_cfg_clear_R12: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> (sbe_cnt == '0 && !thr_irq));

endmodule

bind ecc_hec_mem ecc_hec_mem_chk #(.THR_W(THR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rdy(rdy), .rd_hit(rd_hit), .rd_sbe(rd_sbe),
  .rd_ue(rd_ue), .cfg_we(cfg_we), .sbe_cnt(sbe_cnt), .thr_irq(thr_irq)
);

// File: tb/tb_ecc_hec_mem.sv
module tb_ecc_hec_mem;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 8;
  localparam int DW = 32;
  localparam int CWB = DW + 7;
  localparam int TW = 4;
  localparam int CMAX = (1 << TW) - 1;

  logic clk = 0, rst_n = 0, req = 0, we = 0, cfg_we = 0;
  logic [AW-1:0]  addr = '0;
  logic [DW-1:0]  wdata = '0;
  logic [CWB-1:0] inj_flip = '0;
  logic [TW-1:0]  cfg_thr = '0;
  logic rdy, rd_hit, rd_sbe, rd_ue, thr_irq;
  logic [DW-1:0] rdata;
  logic [TW-1:0] sbe_cnt;

  ecc_hec_mem #(.ADDR_W(AW), .DATA_W(DW), .THR_W(TW)) dut (
    .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr), .wdata(wdata),
    .inj_flip(inj_flip), .rdy(rdy), .rdata(rdata), .rd_hit(rd_hit),
    .rd_sbe(rd_sbe), .rd_ue(rd_ue), .cfg_we(cfg_we), .cfg_thr(cfg_thr),
    .sbe_cnt(sbe_cnt), .thr_irq(thr_irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0, errors = 0;

  typedef struct {
    logic        is_wr;
    logic [DW-1:0] data;
    logic        hit, sbe, ue;
    int          lat, t0;
    string       tag;
  } item_t;
  item_t q[$];

  logic [DW-1:0]  m_data [1 << AW];
  logic [CWB-1:0] m_flip [1 << AW];
  logic           m_cv = 0;
  logic [AW-1:0]  m_ca = '0;
  logic [DW-1:0]  m_cd = '0;
  int             m_cnt = 0, m_thr = 4;
  logic           m_irq = 0;

  task automatic check(string r, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", r, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && rdy) begin
      if (q.size() == 0) begin
        check("R2 unexpected rdy", 64'd1, 64'd0);
      end else begin
        item_t it;
        it = q.pop_front();
        check({it.tag, " latency"}, 64'(cyc - it.t0), 64'(it.lat));
        if (!it.is_wr)
          check({it.tag, " data/hit/sbe/ue"}, {29'd0, rdata, rd_hit, rd_sbe, rd_ue},
                {29'd0, it.data, it.hit, it.sbe, it.ue});
      end
    end
  end

  task automatic access(logic w, logic [AW-1:0] a, logic [DW-1:0] d, logic [CWB-1:0] m, string tag);
    item_t it;
    it.is_wr = w; it.tag = tag; it.hit = 0; it.sbe = 0; it.ue = 0; it.data = '0;
    if (w) begin
      it.lat = 1;
      m_data[a] = d; m_flip[a] = m;
      if (m_cv && m_ca == a) m_cd = d;
    end else if (m_cv && m_ca == a) begin
      it.lat = 1; it.hit = 1; it.data = m_cd;
    end else if ($countones(m_flip[a]) == 1) begin
      it.lat = 6; it.sbe = 1; it.data = m_data[a];
      m_flip[a] = '0; m_cv = 1; m_ca = a; m_cd = m_data[a];
      if (m_cnt < CMAX) m_cnt++;
      if (m_thr != 0 && m_cnt >= m_thr) m_irq = 1;
    end else if ($countones(m_flip[a]) == 2) begin
      it.lat = 3; it.ue = 1; it.data = m_data[a] ^ m_flip[a][DW-1:0];
    end else begin
      it.lat = 3; it.data = m_data[a];
    end
    @(negedge clk);
    it.t0 = cyc;
    q.push_back(it);
    req = 1; we = w; addr = a; wdata = d; inj_flip = m;
    do @(negedge clk); while (!rdy);
    req = 0; inj_flip = '0;
  endtask

  task automatic cfg(int t);
    @(negedge clk);
    cfg_we = 1; cfg_thr = TW'(t);
    @(negedge clk);
    cfg_we = 0;
    m_thr = t; m_cnt = 0; m_irq = 0;
  endtask

  task automatic chk_cnt(string r);
    @(negedge clk);
    check({r, " sbe_cnt"}, 64'(sbe_cnt), 64'(m_cnt));
    check({r, " thr_irq"}, 64'(thr_irq), 64'(m_irq));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    check("watchdog expired", 64'd1, 64'd0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 rdy at reset", 64'(rdy), 64'd0);
    check("R1 sbe_cnt at reset", 64'(sbe_cnt), 64'd0);
    check("R1 thr_irq at reset", 64'(thr_irq), 64'd0);
    rst_n = 1;
    access(1, 8'd5, 32'hCAFE_0005, '0, "R2 write");
    access(0, 8'd5, 32'd0, '0, "R1 R2 clean read");
    access(1, 8'd9, 32'h1234_5678, 39'd1 << 7, "R3 write flip d7");
    access(0, 8'd9, 32'd0, '0, "R3 corrected read");
    chk_cnt("R10 one event");
    access(0, 8'd9, 32'd0, '0, "R5 cache hit");
    access(1, 8'd12, 32'h0F0F_3C3C, 39'd1 << 34, "R8 write flip check bit");
    access(0, 8'd12, 32'd0, '0, "R8 check bit corrected");
    chk_cnt("R8 counted");
    access(0, 8'd9, 32'd0, '0, "R4 R6 repaired word after replace");
    access(0, 8'd12, 32'd0, '0, "R6 new entry hits");
    access(1, 8'd40, 32'h8000_0001, (39'd1 << 3) | (39'd1 << 20), "R9 write two flips");
    access(0, 8'd40, 32'd0, '0, "R9 uncorrectable");
    chk_cnt("R9 no count");
    access(0, 8'd12, 32'd0, '0, "R9 cache unchanged");
    access(0, 8'd40, 32'd0, '0, "R9 no writeback");
    access(1, 8'd12, 32'hDEAD_BEEF, '0, "R7 write cached addr");
    access(0, 8'd12, 32'd0, '0, "R7 hit returns new value");
    cfg(3);
    chk_cnt("R12 cfg clears");
    access(1, 8'd50, 32'h0000_0003, 39'd1 << 0, "R11 flip d0");
    access(0, 8'd50, 32'd0, '0, "R11 event 1");
    access(1, 8'd51, 32'h5555_AAAA, 39'd1 << 31, "R11 flip d31");
    access(0, 8'd51, 32'd0, '0, "R11 event 2");
    chk_cnt("R11 below threshold");
    access(1, 8'd52, 32'h0BAD_F00D, 39'd1 << 38, "R8 flip overall parity");
    access(0, 8'd52, 32'd0, '0, "R8 R11 event 3");
    chk_cnt("R11 threshold reached");
    access(0, 8'd5, 32'd0, '0, "R11 clean read keeps irq");
    chk_cnt("R11 sticky");
    cfg(0);
    chk_cnt("R12 clear to zero threshold");
    for (int i = 0; i < 17; i++) begin
      access(1, AW'(100 + i), 32'h7700_0000 + 32'(i), 39'd1 << (i % 39), "R10 saturation write");
      access(0, AW'(100 + i), 32'd0, '0, "R10 saturation read");
    end
    chk_cnt("R10 R12 saturated, zero threshold silent");
    cfg(2);
    access(1, 8'd200, 32'h1111_2222, 39'd1 << 15, "R12 write");
    access(0, 8'd200, 32'd0, '0, "R12 event 1");
    chk_cnt("R12 new threshold not yet");
    access(1, 8'd201, 32'h3333_4444, 39'd1 << 33, "R12 write");
    access(0, 8'd201, 32'd0, '0, "R12 event 2");
    chk_cnt("R11 R12 new threshold reached");
    repeat (4) @(negedge clk);
    check("R2 scoreboard drained", 64'(q.size()), 64'd0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule